// File: doc/BRIEF.md
# Fractional-N Divider Modulus Controller

This block is the programmable feedback divider of a fractional-N frequency synthesizer. It counts cycles of the fast input clock and marks the end of each division period with a one-cycle pulse. A period lasts either N or N+1 input cycles. The choice is made once per period, at the period boundary, so that the long-run average ratio is N + frac/2^F. Here N is the integer input and frac is the F-bit fractional input. For example, N = 4 with frac = 2^F/4 averages 4.25: three periods of 4 and one of 5 per 17 input cycles.

Three policies decide which periods get the extra cycle. The periodic policy puts all the long periods together in one fixed run in each 2^F-period cycle. The randomized policy compares a full-cycle pseudo-random sequence against the fraction, which gives the same average without a fixed ramp. The first-order sigma-delta policy uses the carry of a phase accumulator, which spreads the long periods as evenly as possible and pushes the error to high frequencies. The modulus-control output reports which choice applies to the period in progress.

Top module: `fnd_modulus_ctrl`

## Requirements
- R1: While reset is asserted with the enable low, the pulse output and the modulus-control output are 0. The first enabled cycle after reset carries a pulse.
- R2: With the enable held high, the number of cycles from one pulse to the next equals the effective N plus the modulus-control value held during that period (1 means N+1).
- R3: The modulus-control output changes only at the clock edge that follows a pulse cycle, so no period mixes N and N+1.
- R4: The integer, fraction and mode inputs take effect only at a period boundary. A change made in the middle of a period does not alter the length of that period.
- R5: In mode 2'b00 (periodic), every 2^F consecutive periods hold exactly frac periods of N+1. These form a single contiguous run when counted cyclically.
- R6: In mode 2'b01 (randomized), a period is N+1 when an F-bit full-cycle pseudo-random value (all 2^F values, zero included) is below frac. Every 2^F consecutive periods hold exactly frac long periods, and for frac = 2^(F-1) they form more than one run.
- R7: In modes 2'b10 and 2'b11 (sigma-delta), the carry of an F-bit accumulator that adds frac once per period selects N+1. Every 2^F consecutive periods hold exactly frac long periods. For frac = 2^(F-2), no two long periods are adjacent, so the long periods form frac separate runs.
- R8: With frac = 0, every period is exactly N cycles and the modulus-control output stays 0, in every mode.
- R9: An integer input below 2 is treated as 2. No two pulses fall on adjacent cycles.
- R10: While the enable is low, no pulse is produced and the count in progress is held. A period interrupted for k cycles ends k cycles later than it would have.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast input clock being divided |
| rst_n | input | 1 | Synchronous active-low reset |
| en | input | 1 | Count enable |
| n_int | input | NW | Integer part of the division ratio |
| frac | input | FW | Fractional part, in units of 2^-FW |
| mode | input | 2 | 00 periodic, 01 randomized, 10/11 sigma-delta |
| div_pulse | output | 1 | One-cycle pulse at the end of each period |
| mod_ctl | output | 1 | 1 when the current period is N+1 cycles |

## Verification
Two events can fall in the same cycle: a period boundary, where the next modulus is chosen and the control inputs are sampled, and an input change or enable drop. The bench changes N two cycles into a period and confirms that the current period keeps its old length while the next one takes the new value. It also drops the enable just after a boundary and measures how much the period stretches. Each policy is then judged over a full 2^F-period window: the window's total cycle count, its number of long periods, and the clustering of those periods into runs are compared against values derived from N and the fraction.

// File: rtl/fnd_pkg.sv
// Package: shared types and helpers for the fractional-N modulus controller.
// Assumes: fraction widths between 3 and 16 bits for the pseudo-random source.
package fnd_pkg;

    typedef enum logic [1:0] {
        MODE_PERIODIC = 2'b00,
        MODE_RANDOM   = 2'b01,
        MODE_SDM      = 2'b10,
        MODE_SDM_ALT  = 2'b11
    } fnd_mode_e;

    // Feedback tap mask of a maximal-length shift register of the given width
    function automatic logic [15:0] prbs_taps(input int width);
        case (width)
            3:       return 16'h0006;
            4:       return 16'h000C;
            5:       return 16'h0014;
            6:       return 16'h0030;
            7:       return 16'h0060;
            8:       return 16'h00B8;
            9:       return 16'h0110;
            10:      return 16'h0240;
            11:      return 16'h0500;
            12:      return 16'h0829;
            13:      return 16'h100D;
            14:      return 16'h2015;
            15:      return 16'h6000;
            16:      return 16'hD008;
            default: return 16'h00B8;
        endcase
    endfunction

endpackage

// File: rtl/fnd_seq_periodic.sv
// Module: periodic modulus policy.
// A phase counter advances once per period. The first frac phases of each
// 2^FW-phase cycle request N+1, so the long periods form one run per cycle.
// Assumes: step is a single-cycle strobe at the period boundary.
module fnd_seq_periodic #(
    parameter int FW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          step,
    input  logic [FW-1:0] frac,
    output logic          sel
);

    logic [FW-1:0] phase;

    // Request the long modulus while the phase lies inside the fraction window
    always_comb sel = (phase < frac);

    // Advance the phase once per period boundary
    always_ff @(posedge clk) begin
        if (!rst_n)    phase <= '0;
        else if (step) phase <= phase + 1'b1;
    end

    // R5: the phase walks through every value, one per period
    p_phase_walk_r5: assert property (@(posedge clk) disable iff (!rst_n)
        step |=> (phase == FW'($past(phase) + 1'b1)));

endmodule

// File: rtl/fnd_seq_prbs.sv
// Module: randomized modulus policy.
// A shift register with a zero-state insertion runs through all 2^FW values
// once per cycle. A period is long when the current value is below frac, so
// each cycle still holds exactly frac long periods.
// Assumes: 3 <= FW <= 16; step is a single-cycle strobe.
module fnd_seq_prbs #(
    parameter int FW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          step,
    input  logic [FW-1:0] frac,
    output logic          sel
);

    import fnd_pkg::*;

    localparam logic [15:0] TAPS16 = prbs_taps(FW);
    localparam logic [FW-1:0] TAPS = TAPS16[FW-1:0];

    logic [FW-1:0] state;
    logic          fb;

    // Request the long modulus when the pseudo-random value is below the fraction
    always_comb sel = (state < frac);

    // Feedback with zero-state insertion, which gives a full 2^FW cycle
    always_comb fb = (^(state & TAPS)) ^ (state[FW-2:0] == '0);

    // Shift once per period boundary
    always_ff @(posedge clk) begin
        if (!rst_n)    state <= '0;
        else if (step) state <= {state[FW-2:0], fb};
    end

    // R6: the sequence never stalls on a value when it is stepped
    p_prbs_moves_r6: assert property (@(posedge clk) disable iff (!rst_n)
        step |=> (state != $past(state)));

endmodule

// File: rtl/fnd_seq_sdm.sv
// Module: first-order sigma-delta modulus policy.
// An FW-bit accumulator adds frac once per period. The carry out of that
// addition requests N+1 for the period that starts.
// Assumes: step is a single-cycle strobe at the period boundary.
module fnd_seq_sdm #(
    parameter int FW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          step,
    input  logic [FW-1:0] frac,
    output logic          sel
);

    logic [FW-1:0] acc;
    logic [FW:0]   sum;

    // Form the widened sum; its top bit is the carry
    always_comb begin
        sum = {1'b0, acc} + {1'b0, frac};
        sel = sum[FW];
    end

    // Keep the residue once per period boundary
    always_ff @(posedge clk) begin
        if (!rst_n)    acc <= '0;
        else if (step) acc <= sum[FW-1:0];
    end

    // R7: after a carry, the residue is smaller than the fraction added
    p_sdm_wrap_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (step && sel) |=> (acc < $past(frac)));

endmodule

// File: rtl/fnd_period_counter.sv
// Module: down-counter that times one division period.
// The pulse is high in the cycle where the count reaches zero with the
// enable high. The reload value (modulus minus one) is taken in that cycle.
// Assumes: load_val >= 1 so that two pulses never touch.
module fnd_period_counter #(
    parameter int CW = 9
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic [CW-1:0] load_val,
    output logic          pulse
);

    logic [CW-1:0] cnt;

    // The terminal cycle of a period
    always_comb pulse = en && (cnt == '0);

    // Count down while enabled and reload at the terminal cycle
    always_ff @(posedge clk) begin
        if (!rst_n)     cnt <= '0;
        else if (pulse) cnt <= load_val;
        else if (en)    cnt <= cnt - 1'b1;
    end

    // R10: a disabled cycle leaves the count untouched
    p_hold_when_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> $stable(cnt));

endmodule

// File: rtl/fnd_modulus_ctrl.sv
// Module: fractional-N divider modulus controller (top).
// Divides clk by N or N+1 per period. At every boundary the policy chosen by
// mode decides whether the next period is long, so that the average ratio
// is N + frac/2^FW. All policies step in parallel and the mode selects one.
// Assumes: control inputs are synchronous to clk; N below 2 is raised to 2.
module fnd_modulus_ctrl #(
    parameter int NW = 8,
    parameter int FW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic [NW-1:0] n_int,
    input  logic [FW-1:0] frac,
    input  logic [1:0]    mode,
    output logic          div_pulse,
    output logic          mod_ctl
);

    import fnd_pkg::*;

    localparam int CW = NW + 1;
    localparam logic [NW-1:0] N_MIN = NW'(2);

    fnd_mode_e     mode_e;
    logic [CW-1:0] n_eff;
    logic [CW-1:0] load_val;
    logic          sel_per;
    logic          sel_rnd;
    logic          sel_sdm;
    logic          sel_next;
    logic          boundary;

    // Decode the mode and clamp the integer part
    always_comb begin
        mode_e = fnd_mode_e'(mode);
        n_eff  = (n_int < N_MIN) ? CW'(N_MIN) : CW'(n_int);
    end

    // Pick the active policy's request
    always_comb begin
        unique case (mode_e)
            MODE_PERIODIC: sel_next = sel_per;
            MODE_RANDOM:   sel_next = sel_rnd;
            default:       sel_next = sel_sdm;
        endcase
    end

    // Reload value for the period that starts at this boundary
    always_comb load_val = n_eff + CW'(sel_next) - CW'(1);

    assign boundary  = div_pulse;

    fnd_period_counter #(.CW(CW)) u_counter (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (en),
        .load_val (load_val),
        .pulse    (div_pulse)
    );

    fnd_seq_periodic #(.FW(FW)) u_periodic (
        .clk   (clk),
        .rst_n (rst_n),
        .step  (boundary),
        .frac  (frac),
        .sel   (sel_per)
    );

    fnd_seq_prbs #(.FW(FW)) u_prbs (
        .clk   (clk),
        .rst_n (rst_n),
        .step  (boundary),
        .frac  (frac),
        .sel   (sel_rnd)
    );

    fnd_seq_sdm #(.FW(FW)) u_sdm (
        .clk   (clk),
        .rst_n (rst_n),
        .step  (boundary),
        .frac  (frac),
        .sel   (sel_sdm)
    );

    // Latch the modulus choice for the whole period that begins
    always_ff @(posedge clk) begin
        if (!rst_n)        mod_ctl <= 1'b0;
        else if (boundary) mod_ctl <= sel_next;
    end

    // R3: the modulus flag moves only after a pulse cycle
    p_mod_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !div_pulse |=> $stable(mod_ctl));

    // R9: the shortest period is two cycles
    p_min_gap_r9: assert property (@(posedge clk) disable iff (!rst_n)
        div_pulse |=> !div_pulse);

    // R8: a zero fraction never selects the long modulus
    p_zero_frac_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (div_pulse && frac == '0) |=> !mod_ctl);

    // R1: no pulse without the enable
    p_pulse_needs_en_r1: assert property (@(posedge clk) disable iff (!rst_n)
        div_pulse |-> en);

endmodule

// File: tb/test_fnd_modulus_ctrl.sv
module test_fnd_modulus_ctrl;

    localparam int NW  = 8;
    localparam int FW  = 8;
    localparam int WIN = 1 << FW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          en = 1'b0;
    logic [NW-1:0] n_int = NW'(4);
    logic [FW-1:0] frac = '0;
    logic [1:0]    mode = 2'b00;
    logic          div_pulse;
    logic          mod_ctl;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    logic hist [WIN];

    always #4 clk = ~clk;

    fnd_modulus_ctrl #(.NW(NW), .FW(FW)) i_fnd_modulus_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (en),
        .n_int     (n_int),
        .frac      (frac),
        .mode      (mode),
        .div_pulse (div_pulse),
        .mod_ctl   (mod_ctl)
    );

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            errors = errors + 1;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
            finish_run();
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic sync_pulse();
        @(negedge clk);
        while (!div_pulse) @(negedge clk);
    endtask

    // Measure one 2^FW-period window; returns the number of long-period runs
    task automatic run_window(input int nv, input int fv, input int md,
                              input string req, output int runs);
        int neff, total, ones, bad_len, bad_hold;
        n_int = NW'(nv); frac = FW'(fv); mode = 2'(md);
        neff = (nv < 2) ? 2 : nv;
        sync_pulse();
        total = 0; ones = 0; bad_len = 0; bad_hold = 0;
        for (int p = 0; p < WIN; p++) begin
            int cyc;
            logic mc;
            cyc = 0;
            mc = 1'b0;
            do begin
                @(negedge clk);
                cyc++;
                if (cyc == 1) mc = mod_ctl;
                else if (mod_ctl != mc) bad_hold++;
            end while (!div_pulse);
            if (cyc != neff + int'(mod_ctl)) bad_len++;
            hist[p] = mod_ctl;
            ones += int'(mod_ctl);
            total += cyc;
        end
        runs = 0;
        for (int p = 0; p < WIN; p++)
            if (hist[p] && !hist[(p + WIN - 1) % WIN]) runs++;
        check(bad_len == 0, {"R2 ", req}, bad_len, 0);
        check(bad_hold == 0, {"R3 ", req}, bad_hold, 0);
        check(total == neff * WIN + fv, {req, " total"}, total, neff * WIN + fv);
        check(ones == fv, {req, " long count"}, ones, fv);
    endtask

    task automatic t_reset();
        rst_n = 1'b0; en = 1'b0;
        repeat (3) @(negedge clk);
        check(div_pulse == 1'b0, "R1 pulse in reset", int'(div_pulse), 0);
        check(mod_ctl == 1'b0, "R1 mod_ctl in reset", int'(mod_ctl), 0);
        rst_n = 1'b1; en = 1'b1;
        #1;
        check(div_pulse == 1'b1, "R1 first enabled cycle", int'(div_pulse), 1);
    endtask

    task automatic t_periodic();
        int runs;
        run_window(4, WIN / 4, 0, "R5 periodic 4.25", runs);
        check(runs == 1, "R5 single run", runs, 1);
        run_window(5, 0, 0, "R8 periodic zero", runs);
        check(runs == 0, "R8 periodic no long", runs, 0);
    endtask

    task automatic t_random();
        int runs;
        run_window(4, WIN / 4, 1, "R6 random 4.25", runs);
        run_window(3, WIN / 2, 1, "R6 random half", runs);
        check(runs > 1, "R6 scattered", runs, 2);
        run_window(5, 0, 1, "R8 random zero", runs);
    endtask

    task automatic t_sdm();
        int runs;
        run_window(4, WIN / 4, 2, "R7 sdm 4.25", runs);
        check(runs == WIN / 4, "R7 isolated long periods", runs, WIN / 4);
        run_window(3, WIN - 1, 3, "R7 sdm near one", runs);
        run_window(5, 0, 2, "R8 sdm zero", runs);
    endtask

    task automatic t_clamp();
        int runs;
        run_window(1, 0, 0, "R9 N=1", runs);
        run_window(0, WIN / 2, 2, "R9 N=0 half", runs);
    endtask

    task automatic t_midperiod();
        int cyc;
        n_int = NW'(5); frac = '0; mode = 2'b00;
        sync_pulse();
        sync_pulse();
        cyc = 0;
        @(negedge clk); cyc++;
        @(negedge clk); cyc++;
        n_int = NW'(9);
        do begin @(negedge clk); cyc++; end while (!div_pulse);
        check(cyc == 5, "R4 current period unchanged", cyc, 5);
        cyc = 0;
        do begin @(negedge clk); cyc++; end while (!div_pulse);
        check(cyc == 9, "R4 next period uses new N", cyc, 9);
    endtask

    task automatic t_enable();
        int cyc, seen;
        n_int = NW'(6); frac = '0; mode = 2'b00;
        sync_pulse();
        sync_pulse();
        cyc = 0; seen = 0;
        @(negedge clk); cyc++;
        en = 1'b0;
        repeat (10) begin
            @(negedge clk); cyc++;
            if (div_pulse) seen++;
        end
        en = 1'b1;
        #1;
        if (div_pulse) seen++;
        check(seen == 0, "R10 no pulse while disabled", seen, 0);
        while (!div_pulse) begin @(negedge clk); cyc++; end
        check(cyc == 16, "R10 stretched period", cyc, 16);
    endtask

    initial begin
        t_reset();
        t_periodic();
        t_random();
        t_sdm();
        t_clamp();
        t_midperiod();
        t_enable();
        finish_run();
    end

endmodule